// File: doc/BRIEF.md
# Range-Selectable Phase Comparator

This block measures how far the motor's frequency-generator (FG) strobe lags or leads an internal reference pulse train and turns that error into an 8-bit phase control code for a speed servo. The reference train is built from the prescaler tick: one reference pulse every `NOM_TICKS` enabled ticks, which is the nominal FG period. The error is kept unwrapped across whole periods, so the comparator can report errors larger than one period when a wider range is chosen.

A 2-bit range select picks one of three comparison spans or a test code. The standard span covers one nominal period (2π) and refreshes the code on every FG strobe. The double span covers three periods (6π) and refreshes on every second strobe. The quadruple span covers seven periods (14π) and refreshes on every fourth strobe. A limiter pins the code at its ends. The two wide spans add hysteresis, so a clamped code does not chatter near the limit. A speed discriminator upstream can force the code to full scale (drive) or to zero (brake or stop). An update strobe marks each cycle in which a fresh tracking code appears.

Top module: `phase_range_comparator`

## Requirements
- R1: After reset, `po_code` is 0x80 and `po_update` is 0. The error tracking restarts at zero.
- R2: At an FG strobe the error is E = T − NOM_TICKS·F. T counts the cycles with `tick_en` high since reset, including the strobe cycle. F counts the FG strobes since reset, including this one. A cycle with `tick_en` low does not advance T.
- R3: Range select 00 (standard) refreshes the code on every strobe. The code is 128 + (E·128)/L, with the division truncated toward zero and L = NOM_TICKS/2. The code saturates to 0xFF for E ≥ L and to 0x00 for E ≤ −L. This range has no hysteresis.
- R4: Range select 11 (double) uses L = 3·NOM_TICKS/2. It refreshes the code only on every second strobe, counted from the last change of range select.
- R5: Range select 10 (quadruple) uses L = 7·NOM_TICKS/2. It refreshes the code only on every fourth strobe, counted from the last change of range select.
- R6: In the double and quadruple ranges, a refresh with E ≥ L or E ≤ −L clamps the code. A high clamp holds 0xFF over later refreshes until E ≤ L − L/8. A low clamp holds 0x00 until E ≥ −(L − L/8). L/8 is integer division. When a clamp is released, the code follows the formula in R3.
- R7: Range select 01 (test) drives the code to 0x80 and pulses `po_update` on every FG strobe.
- R8: Override request 01 (drive) forces `po_code` to 0xFF. Requests 10 (brake) and 11 (stop) force it to 0x00. The forced value appears in the cycle after the request is sampled, and `po_update` stays 0 while a request is active. Comparison continues during the override. When the request returns to 00, the code held from the last refresh appears.
- R9: A refresh shows on `po_code` and `po_update` in the cycle after the clock edge that samples the strobe. `po_update` is a one-cycle pulse. With no override, `po_code` holds between refreshes.
- R10: Changing range select restarts the refresh count and clears any hysteresis clamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Prescaler tick enable; advances the reference train |
| fg_pulse | input | 1 | One-cycle FG strobe |
| range_sel | input | 2 | 00 standard, 11 double, 10 quadruple, 01 test |
| ovr_req | input | 2 | 00 track, 01 drive, 10 brake, 11 stop |
| po_code | output | 8 | Phase control code |
| po_update | output | 1 | Pulses for one cycle when a tracking code is refreshed |

## Verification
A wrong tick position or slip count shows up in `po_code` at the very next refresh, as an offset from the value computed from the strobe's arrival time. The sweeps move the FG arrival time slowly in steps of a few ticks, so every code step is checked. A refresh counter that has lost its place moves `po_update` to the wrong strobe within one group of two or four strobes. A hysteresis flag that is stuck or cleared too early shows up as a code that leaves full scale too soon or too late, on the first refresh inside the release band. The sweeps cross that band in both directions.

// File: rtl/phc_pkg.sv
package phc_pkg;

    typedef enum logic [1:0] {
        RNG_STD  = 2'b00,
        RNG_TEST = 2'b01,
        RNG_QUAD = 2'b10,
        RNG_DBL  = 2'b11
    } rng_t;

    typedef enum logic [1:0] {
        OVR_NONE  = 2'b00,
        OVR_DRIVE = 2'b01,
        OVR_BRAKE = 2'b10,
        OVR_STOP  = 2'b11
    } ovr_t;

    typedef enum logic [1:0] {
        CL_NONE = 2'b00,
        CL_HI   = 2'b01,
        CL_LO   = 2'b10
    } clamp_t;

    localparam logic [7:0] CODE_MID  = 8'h80;
    localparam logic [7:0] CODE_FULL = 8'hFF;
    localparam logic [7:0] CODE_ZERO = 8'h00;

endpackage

// File: rtl/phc_refgen.sv
module phc_refgen #(
    parameter int NOM_TICKS = 64,
    parameter int CW        = $clog2(NOM_TICKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    output logic          ref_pulse,
    output logic [CW-1:0] phase_next
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ref_st_t;

    localparam logic [CW-1:0] LAST = CW'(NOM_TICKS - 1);

    ref_st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        ref_pulse = 1'b0;
        if (tick_en) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt  = '0;
                ref_pulse = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        phase_next = st_d.cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/phc_errtrack.sv
module phc_errtrack #(
    parameter int NOM_TICKS = 64,
    parameter int SLIP_MAX  = 8,
    parameter int CW        = $clog2(NOM_TICKS),
    parameter int SW        = $clog2(SLIP_MAX) + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_pulse,
    input  logic               fg_pulse,
    input  logic [CW-1:0]      phase_next,
    output logic signed [31:0] err_now
);

    typedef struct packed {
        logic signed [SW-1:0] slip;
    } trk_st_t;

    trk_st_t st_q, st_d;
    int      sum;
    int      sum_sat;

    always_comb begin
        st_d = st_q;
        sum  = int'(st_q.slip) + (ref_pulse ? 1 : 0) - (fg_pulse ? 1 : 0);
        if (sum > SLIP_MAX)       sum_sat = SLIP_MAX;
        else if (sum < -SLIP_MAX) sum_sat = -SLIP_MAX;
        else                      sum_sat = sum;
        st_d.slip = SW'(sum_sat);
        err_now   = sum_sat * NOM_TICKS + int'({1'b0, phase_next});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/phc_scale.sv
module phc_scale
    import phc_pkg::*;
#(
    parameter int NOM_TICKS = 64
) (
    input  rng_t               rng,
    input  logic signed [31:0] err,
    input  clamp_t             clamp_in,
    output logic [7:0]         code,
    output clamp_t             clamp_out
);

    localparam int NSPAN = 3;

    int lim_w [NSPAN];
    int rel_w [NSPAN];
    int raw_w [NSPAN];

    for (genvar g = 0; g < NSPAN; g++) begin : g_span
        localparam int MULT = (2 << g) - 1;
        localparam int LIM  = (NOM_TICKS / 2) * MULT;
        assign lim_w[g] = LIM;
        assign rel_w[g] = LIM - LIM / 8;
        assign raw_w[g] = 128 + (int'(err) * 128) / LIM;
    end

    int     sel;
    int     lim;
    int     rel;
    int     raw;
    logic   wide;
    clamp_t st;

    always_comb begin
        case (rng)
            RNG_DBL:  sel = 1;
            RNG_QUAD: sel = 2;
            default:  sel = 0;
        endcase
        wide = (rng == RNG_DBL) || (rng == RNG_QUAD);
        lim  = lim_w[sel];
        rel  = rel_w[sel];
        raw  = raw_w[sel];
        st   = wide ? clamp_in : CL_NONE;
        code = CODE_MID;

        if (rng == RNG_TEST) begin
            st   = CL_NONE;
            code = CODE_MID;
        end else begin
            if (st == CL_HI && int'(err) <= rel)  st = CL_NONE;
            if (st == CL_LO && int'(err) >= -rel) st = CL_NONE;
            if (st == CL_HI) begin
                code = CODE_FULL;
            end else if (st == CL_LO) begin
                code = CODE_ZERO;
            end else if (int'(err) >= lim) begin
                code = CODE_FULL;
                st   = wide ? CL_HI : CL_NONE;
            end else if (int'(err) <= -lim) begin
                code = CODE_ZERO;
                st   = wide ? CL_LO : CL_NONE;
            end else begin
                code = raw[7:0];
            end
        end
        clamp_out = st;
    end

endmodule

// File: rtl/phase_range_comparator.sv
module phase_range_comparator
    import phc_pkg::*;
#(
    parameter int NOM_TICKS = 64,
    parameter int SLIP_MAX  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       fg_pulse,
    input  logic [1:0] range_sel,
    input  logic [1:0] ovr_req,
    output logic [7:0] po_code,
    output logic       po_update
);

    localparam int CW    = $clog2(NOM_TICKS);
    localparam int GRP_W = $clog2(4);

    typedef struct packed {
        rng_t             rng;
        logic [GRP_W-1:0] cnt;
        clamp_t           clamp;
        logic [7:0]       code;
        logic [7:0]       out;
        logic             upd;
    } top_st_t;

    logic               ref_pulse;
    logic [CW-1:0]      phase_next;
    logic signed [31:0] err_now;
    logic [7:0]         sc_code;
    clamp_t             sc_clamp;
    rng_t               rng_now;
    ovr_t               ovr_now;
    clamp_t             cl_base;
    logic [GRP_W-1:0]   cnt_base;
    logic [GRP_W-1:0]   cnt_last;
    logic               hit;

    top_st_t st_q, st_d;

    phc_refgen #(.NOM_TICKS(NOM_TICKS), .CW(CW)) u_refgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .ref_pulse  (ref_pulse),
        .phase_next (phase_next)
    );

    phc_errtrack #(.NOM_TICKS(NOM_TICKS), .SLIP_MAX(SLIP_MAX), .CW(CW)) u_errtrack (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_pulse  (ref_pulse),
        .fg_pulse   (fg_pulse),
        .phase_next (phase_next),
        .err_now    (err_now)
    );

    phc_scale #(.NOM_TICKS(NOM_TICKS)) u_scale (
        .rng       (rng_now),
        .err       (err_now),
        .clamp_in  (cl_base),
        .code      (sc_code),
        .clamp_out (sc_clamp)
    );

    always_comb begin
        rng_now  = rng_t'(range_sel);
        ovr_now  = ovr_t'(ovr_req);
        cnt_base = (rng_now != st_q.rng) ? '0 : st_q.cnt;
        cl_base  = (rng_now != st_q.rng) ? CL_NONE : st_q.clamp;
        case (rng_now)
            RNG_DBL:  cnt_last = GRP_W'(1);
            RNG_QUAD: cnt_last = GRP_W'(3);
            default:  cnt_last = '0;
        endcase

        st_d       = st_q;
        st_d.rng   = rng_now;
        st_d.cnt   = cnt_base;
        st_d.clamp = cl_base;
        st_d.upd   = 1'b0;
        hit        = 1'b0;

        if (fg_pulse) begin
            if (cnt_base == cnt_last) begin
                hit      = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = cnt_base + 1'b1;
            end
        end

        if (hit) begin
            st_d.code  = sc_code;
            st_d.clamp = sc_clamp;
            st_d.upd   = (ovr_now == OVR_NONE);
        end

        case (ovr_now)
            OVR_NONE:  st_d.out = st_d.code;
            OVR_DRIVE: st_d.out = CODE_FULL;
            default:   st_d.out = CODE_ZERO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.rng   <= RNG_STD;
            st_q.cnt   <= '0;
            st_q.clamp <= CL_NONE;
            st_q.code  <= CODE_MID;
            st_q.out   <= CODE_MID;
            st_q.upd   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign po_code   = st_q.out;
    assign po_update = st_q.upd;

endmodule

// File: rtl/phase_range_comparator_chk.sv
module phase_range_comparator_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fg_pulse,
    input logic [1:0] range_sel,
    input logic [1:0] ovr_req,
    input logic [7:0] po_code,
    input logic       po_update
);

    logic live1_q;
    logic live2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live1_q <= 1'b0;
            live2_q <= 1'b0;
        end else begin
            live1_q <= 1'b1;
            live2_q <= live1_q;
        end
    end

    // R8: drive request forces full scale
    p_drive_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (live1_q && $past(ovr_req) == 2'b01) |-> po_code == 8'hFF);

    // R8: brake or stop request forces zero
    p_brake_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (live1_q && $past(ovr_req[1])) |-> po_code == 8'h00);

    // R9: an update strobe follows a sampled FG strobe with no override
    p_update_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        po_update |-> (live1_q && $past(fg_pulse) && $past(ovr_req) == 2'b00));

    // R9: the update strobe lasts one cycle
    p_update_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        po_update |=> !po_update);

    // R7: test range shows mid code on update
    p_test_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (po_update && $past(range_sel) == 2'b01) |-> po_code == 8'h80);

    // R9: code holds between refreshes when nothing overrides it
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (live2_q && !po_update && $past(ovr_req) == 2'b00 && $past(ovr_req, 2) == 2'b00)
        |-> $stable(po_code));

endmodule

bind phase_range_comparator phase_range_comparator_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fg_pulse  (fg_pulse),
    .range_sel (range_sel),
    .ovr_req   (ovr_req),
    .po_code   (po_code),
    .po_update (po_update)
);

// File: tb/phase_range_comparator_bench.sv
module phase_range_comparator_bench;

    localparam int NOM = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       fg_pulse = 1'b0;
    logic [1:0] range_sel = 2'b00;
    logic [1:0] ovr_req = 2'b00;
    logic [7:0] po_code;
    logic       po_update;

    int n_ticks = 0;
    int n_fg    = 0;
    int chk_cnt = 0;
    int fail_cnt = 0;
    int held    = 128;
    int cl      = 0;   // 0 none, 1 high, 2 low
    int grp     = 0;

    always #2 clk = ~clk;

    phase_range_comparator #(.NOM_TICKS(NOM), .SLIP_MAX(8)) u_phase_range_comparator (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .fg_pulse  (fg_pulse),
        .range_sel (range_sel),
        .ovr_req   (ovr_req),
        .po_code   (po_code),
        .po_update (po_update)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        chk_cnt++;
        if (!ok) begin
            fail_cnt++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic t, input logic f);
        tick_en  = t;
        fg_pulse = f;
        @(posedge clk);
        @(negedge clk);
        tick_en  = 1'b0;
        fg_pulse = 1'b0;
        if (t) n_ticks++;
        if (f) n_fg++;
    endtask

    task automatic set_range(input logic [1:0] r);
        range_sel = r;
        cyc(1'b1, 1'b0);
        grp = 0;
        cl  = 0;
    endtask

    function automatic int span_lim(input logic [1:0] r);
        if (r == 2'b11) return 3 * NOM / 2;
        if (r == 2'b10) return 7 * NOM / 2;
        return NOM / 2;
    endfunction

    task automatic model_code(input int e, output int code);
        int L;
        int H;
        L = span_lim(range_sel);
        H = L - L / 8;
        if (range_sel == 2'b00) begin
            cl = 0;
            if (e >= L)       code = 255;
            else if (e <= -L) code = 0;
            else              code = 128 + (e * 128) / L;
        end else begin
            if (cl == 1 && e <= H)  cl = 0;
            if (cl == 2 && e >= -H) cl = 0;
            if (cl == 1)            code = 255;
            else if (cl == 2)       code = 0;
            else if (e >= L) begin code = 255; cl = 1; end
            else if (e <= -L) begin code = 0; cl = 2; end
            else                    code = 128 + (e * 128) / L;
        end
    endtask

    task automatic fg_err(input int e, input string tag);
        int   c;
        int   need;
        int   exp_code;
        logic upd;
        c = (n_fg + 1) * NOM + e - n_ticks;
        if (c < 1) c = 1;
        for (int i = 0; i < c - 1; i++) cyc(1'b1, 1'b0);
        cyc(1'b1, 1'b1);
        e = n_ticks - n_fg * NOM;
        upd = 1'b0;
        if (range_sel == 2'b01 || range_sel == 2'b00) begin
            upd = 1'b1;
        end else begin
            need = (range_sel == 2'b11) ? 2 : 4;
            grp++;
            if (grp == need) begin
                upd = 1'b1;
                grp = 0;
            end
        end
        if (upd) begin
            if (range_sel == 2'b01) begin
                held = 128;
                cl   = 0;
            end else begin
                model_code(e, exp_code);
                held = exp_code;
            end
        end
        if (ovr_req == 2'b00) begin
            check(po_update == upd, {tag, " update"}, int'(po_update), int'(upd));
            check(int'(po_code) == held, {tag, " code"}, int'(po_code), held);
        end else begin
            check(po_update == 1'b0, {tag, " R8 update suppressed"}, int'(po_update), 0);
            check(int'(po_code) == ((ovr_req == 2'b01) ? 255 : 0), {tag, " R8 forced"},
                  int'(po_code), (ovr_req == 2'b01) ? 255 : 0);
        end
    endtask

    initial begin
        #(4 * 190000);
        chk_cnt++;
        fail_cnt++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check(po_code == 8'h80, "R1 reset code", int'(po_code), 128);
        check(po_update == 1'b0, "R1 reset strobe", int'(po_update), 0);

        // R3 standard range sweep, R2 error definition
        for (int e = 0; e <= 40; e += 2) fg_err(e, "R3 std up");
        for (int e = 38; e >= -40; e -= 2) fg_err(e, "R3 std down");
        for (int e = -38; e <= 0; e += 2) fg_err(e, "R3 std back");

        // R2 disabled ticks do not advance the reference
        for (int i = 0; i < 9; i++) cyc(1'b0, 1'b0);
        fg_err(5, "R2 tick gate");
        for (int i = 0; i < 13; i++) cyc(1'b0, 1'b0);
        fg_err(-7, "R2 tick gate");

        // R9 hold between refreshes
        for (int i = 0; i < 5; i++) begin
            cyc(1'b1, 1'b0);
            check(po_update == 1'b0 && int'(po_code) == held, "R9 hold",
                  int'(po_code), held);
        end

        // R4 / R6 double range with hysteresis
        set_range(2'b11);
        for (int e = 0; e <= 120; e += 2) fg_err(e, "R4 R6 dbl up");
        // R10 range change clears the clamp and restarts the count
        set_range(2'b00);
        fg_err(116, "R10 std between");
        set_range(2'b11);
        fg_err(88, "R10 dbl first");
        fg_err(88, "R10 dbl second");
        for (int e = 86; e >= -120; e -= 2) fg_err(e, "R4 R6 dbl down");
        for (int e = -118; e <= 0; e += 2) fg_err(e, "R4 R6 dbl back");

        // R5 / R6 quadruple range
        set_range(2'b10);
        for (int e = 0; e <= 248; e += 4) fg_err(e, "R5 R6 quad up");
        for (int e = 244; e >= -248; e -= 4) fg_err(e, "R5 R6 quad down");
        for (int e = -244; e <= 0; e += 4) fg_err(e, "R5 R6 quad back");

        // R7 test mode
        set_range(2'b01);
        fg_err(10, "R7 test");
        fg_err(-20, "R7 test");
        fg_err(3, "R7 test");

        // R8 overrides in standard range
        set_range(2'b00);
        fg_err(8, "R8 pre");
        ovr_req = 2'b01;
        cyc(1'b1, 1'b0);
        check(po_code == 8'hFF, "R8 drive", int'(po_code), 255);
        fg_err(20, "R8 drive fg");
        ovr_req = 2'b10;
        cyc(1'b1, 1'b0);
        check(po_code == 8'h00, "R8 brake", int'(po_code), 0);
        fg_err(-12, "R8 brake fg");
        ovr_req = 2'b11;
        cyc(1'b1, 1'b0);
        check(po_code == 8'h00, "R8 stop", int'(po_code), 0);
        ovr_req = 2'b00;
        cyc(1'b1, 1'b0);
        check(int'(po_code) == held, "R8 release", int'(po_code), held);
        check(po_update == 1'b0, "R8 release strobe", int'(po_update), 0);
        fg_err(4, "R8 after");

        $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
        $finish;
    end

endmodule